// File: doc/BRIEF.md
# Reset Boot-Source Selection Sequencer

After every core reset, this block decides where the processor starts. It can start in the on-chip ROM loader or in the user application held in flash. First it clears the address-map select, so flash is visible at address zero. Next it examines a committed 32-bit boot configuration word. If the word enables it, the block samples one GPIO pin and compares it with a configured level. If the pin does not decide the outcome, the block reads the application's reset vector from flash. An erased (all-ones) vector sends the processor to the ROM loader. A valid vector makes the block also fetch the initial stack pointer and start the application.

The block does not start until the power-on reset indication `por_ok` is high. While `por_ok` is low, the block behaves as if held in reset. Flash is reached through a request channel that uses valid/ready handshaking, plus a response channel that the block always accepts. A request stays asserted, with a stable address, until the slave takes it with `flash_req_ready`. The slave must answer each accepted request with exactly one `flash_rsp_valid` cycle. It may stall for any number of cycles, and the sequencer waits for the response before it uses the word. The result is presented as follows:

- a one-cycle `boot_done` pulse,
- a `rom_boot` flag,
- the map-select level `map_rom`,
- registered stack-pointer and program-counter values.

Top module: `boot_src_seq`

## Requirements
- R1: While `rst_n` is low, `boot_done`, `map_rom`, `rom_boot` and `flash_req_valid` are 0, and `sp_out` and `pc_out` are 0.
- R2: While `por_ok` is low, the sequence does not advance. From the next cycle, `flash_req_valid`, `boot_done` and `map_rom` are 0. The sequence starts once `por_ok` is high.
- R3: The pin check is enabled only when configuration bit 8 is 0. When bit 8 is 1, the pin level is ignored and the reset vector is always read.
- R4: With the check enabled and the selected pin equal to the polarity bit, the ROM path is taken without any flash read. `map_rom` and `rom_boot` become 1, `sp_out`/`pc_out` take the ROM vectors `ROM_SP`/`ROM_PC`, and `boot_done` pulses 2 cycles after the sequence starts.
- R5: Otherwise, flash address 0x4 is read first. If that word is 0xFFFF_FFFF, the ROM path is taken as in R4, and `boot_done` pulses 4 cycles after the start when the slave never stalls.
- R6: If the word at 0x4 is not all-ones, it becomes `pc_out`. A second read of address 0x0 supplies `sp_out`. `rom_boot` and `map_rom` stay 0, and `boot_done` pulses 6 cycles after the start when the slave never stalls.
- R7: The GPIO bus is split into ports of 8 pins, with pin p of port n at bit n*8+p. Configuration bits [15:13] select the port, [12:10] the pin and bit 9 the matching level. Bits [7:0] have no effect.
- R8: `boot_done` is high for exactly one cycle per completed sequence.
- R9: A flash request held without `flash_req_ready` stays valid with an unchanged address. Each stall cycle delays completion by one cycle.
- R10: Asserting `rst_n` in the middle of the sequence aborts it. After release, the sequence restarts from the map-clear step.
- R11: After `boot_done`, `sp_out`, `pc_out` and `map_rom` hold their values and no further flash request is issued until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low core reset |
| por_ok | input | 1 | Power-on reset released |
| boot_cfg | input | 32 | Committed boot configuration word |
| gpio_levels | input | NPORT*PINS | Sampled GPIO pin levels |
| flash_req_valid | output | 1 | Flash read request valid |
| flash_req_ready | input | 1 | Flash accepts the request |
| flash_req_addr | output | ADDR_W | Flash read address |
| flash_rsp_valid | input | 1 | Read data valid |
| flash_rsp_data | input | DATA_W | Read data |
| map_rom | output | 1 | 1: ROM aliased at address 0 |
| rom_boot | output | 1 | ROM loader selected |
| boot_done | output | 1 | One-cycle completion strobe |
| sp_out | output | DATA_W | Initial stack pointer |
| pc_out | output | DATA_W | Initial program counter |

## Verification
Each result has a known due cycle, counted from the first rising edge after reset release (or after `por_ok` rises):

- cycle 2 for the pin-selected ROM path;
- cycle 4 for the erased-vector path;
- cycle 6 for an application start;
- one extra cycle for every cycle the bench holds `flash_req_ready` low.

Inputs are driven and outputs sampled on falling edges. The bench counts falling edges until `boot_done` is seen and compares that count with the due cycle. It then checks the flags and vectors in that same sample, and checks one sample later that the strobe has dropped. Its flash model logs every accepted address, so flash reads that are missing or extra show up on each path.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
  // configuration word field positions (decoded by the pin selector)
  localparam int CFG_ENA_N_BIT = 8;
  localparam int CFG_POL_BIT   = 9;
  localparam int CFG_PIN_LSB   = 10;
  localparam int CFG_PORT_LSB  = 13;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DECIDE,
    S_VEC_REQ,
    S_VEC_WAIT,
    S_SP_REQ,
    S_SP_WAIT,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/boot_pin_sel.sv
module boot_pin_sel
  import boot_sel_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int PINS  = 8
) (
  input  logic [31:0]            cfg,
  input  logic [NPORT*PINS-1:0]  gpio,
  output logic                   check_en,
  output logic                   pin_match
);
  localparam int PORT_W = $clog2(NPORT);
  localparam int PIN_W  = $clog2(PINS);

  logic [PORT_W-1:0] port_idx;
  logic [PIN_W-1:0]  pin_idx;
  logic [NPORT-1:0]  port_lvl;
  logic              unused_cfg;

  assign port_idx   = cfg[CFG_PORT_LSB +: PORT_W];
  assign pin_idx    = cfg[CFG_PIN_LSB +: PIN_W];
  assign unused_cfg = ^{cfg[31:16], cfg[7:0]};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [PINS-1:0] bits;
    assign bits        = gpio[p*PINS +: PINS];
    assign port_lvl[p] = bits[pin_idx];
  end

  assign check_en  = ~cfg[CFG_ENA_N_BIT];
  assign pin_match = (port_lvl[port_idx] == cfg[CFG_POL_BIT]);
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 'h4,
  parameter logic [ADDR_W-1:0] SP_ADDR  = 'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_ok,
  input  logic              check_en,
  input  logic              pin_match,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic              ev_clear,
  output logic              ev_rom,
  output logic              ev_pc,
  output logic              ev_app
);
  seq_state_e state, nxt;
  logic erased;

  assign erased = &rsp_data;

  always_comb begin
    nxt      = state;
    ev_clear = 1'b0;
    ev_rom   = 1'b0;
    ev_pc    = 1'b0;
    ev_app   = 1'b0;
    unique case (state)
      S_IDLE: begin
        ev_clear = 1'b1;
        nxt      = S_DECIDE;
      end
      S_DECIDE: begin
        if (check_en && pin_match) begin
          ev_rom = 1'b1;
          nxt    = S_DONE;
        end else begin
          nxt = S_VEC_REQ;
        end
      end
      S_VEC_REQ:  if (req_ready) nxt = S_VEC_WAIT;
      S_VEC_WAIT: if (rsp_valid) begin
        if (erased) begin
          ev_rom = 1'b1;
          nxt    = S_DONE;
        end else begin
          ev_pc = 1'b1;
          nxt   = S_SP_REQ;
        end
      end
      S_SP_REQ:   if (req_ready) nxt = S_SP_WAIT;
      S_SP_WAIT:  if (rsp_valid) begin
        ev_app = 1'b1;
        nxt    = S_DONE;
      end
      default:    nxt = S_DONE;
    endcase
    if (!por_ok) begin
      nxt      = S_IDLE;
      ev_clear = 1'b1;
      ev_rom   = 1'b0;
      ev_pc    = 1'b0;
      ev_app   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign req_valid = (state == S_VEC_REQ) || (state == S_SP_REQ);
  assign req_addr  = (state == S_SP_REQ) ? SP_ADDR : VEC_ADDR;
endmodule

// File: rtl/boot_vec_regs.sv
module boot_vec_regs #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ROM_SP = '0,
  parameter logic [DATA_W-1:0] ROM_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_clear,
  input  logic              ev_rom,
  input  logic              ev_pc,
  input  logic              ev_app,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              map_rom,
  output logic              rom_boot,
  output logic              boot_done,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] pc_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_rom   <= 1'b0;
      rom_boot  <= 1'b0;
      boot_done <= 1'b0;
      sp_out    <= '0;
      pc_out    <= '0;
    end else begin
      boot_done <= 1'b0;
      if (ev_clear) begin
        map_rom  <= 1'b0;
        rom_boot <= 1'b0;
        sp_out   <= '0;
        pc_out   <= '0;
      end else if (ev_rom) begin
        map_rom   <= 1'b1;
        rom_boot  <= 1'b1;
        sp_out    <= ROM_SP;
        pc_out    <= ROM_PC;
        boot_done <= 1'b1;
      end else if (ev_pc) begin
        pc_out <= rsp_data;
      end else if (ev_app) begin
        sp_out    <= rsp_data;
        boot_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_src_seq.sv
module boot_src_seq #(
  parameter int NPORT  = 8,
  parameter int PINS   = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ROM_SP = 32'h2000_1000,
  parameter logic [DATA_W-1:0] ROM_PC = 32'h0100_0101
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    por_ok,
  input  logic [31:0]             boot_cfg,
  input  logic [NPORT*PINS-1:0]   gpio_levels,
  output logic                    flash_req_valid,
  input  logic                    flash_req_ready,
  output logic [ADDR_W-1:0]       flash_req_addr,
  input  logic                    flash_rsp_valid,
  input  logic [DATA_W-1:0]       flash_rsp_data,
  output logic                    map_rom,
  output logic                    rom_boot,
  output logic                    boot_done,
  output logic [DATA_W-1:0]       sp_out,
  output logic [DATA_W-1:0]       pc_out
);
  logic check_en, pin_match;
  logic ev_clear, ev_rom, ev_pc, ev_app;

  boot_pin_sel #(.NPORT(NPORT), .PINS(PINS)) u_pin (
    .cfg(boot_cfg), .gpio(gpio_levels),
    .check_en(check_en), .pin_match(pin_match)
  );

  boot_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok),
    .check_en(check_en), .pin_match(pin_match),
    .req_ready(flash_req_ready), .rsp_valid(flash_rsp_valid),
    .rsp_data(flash_rsp_data),
    .req_valid(flash_req_valid), .req_addr(flash_req_addr),
    .ev_clear(ev_clear), .ev_rom(ev_rom), .ev_pc(ev_pc), .ev_app(ev_app)
  );

  boot_vec_regs #(.DATA_W(DATA_W), .ROM_SP(ROM_SP), .ROM_PC(ROM_PC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ev_clear(ev_clear), .ev_rom(ev_rom), .ev_pc(ev_pc), .ev_app(ev_app),
    .rsp_data(flash_rsp_data),
    .map_rom(map_rom), .rom_boot(rom_boot), .boot_done(boot_done),
    .sp_out(sp_out), .pc_out(pc_out)
  );
endmodule

// File: rtl/boot_src_seq_chk.sv
module boot_src_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              por_ok,
  input logic              flash_req_valid,
  input logic              flash_req_ready,
  input logic [ADDR_W-1:0] flash_req_addr,
  input logic              map_rom,
  input logic              rom_boot,
  input logic              boot_done,
  input logic [DATA_W-1:0] sp_out,
  input logic [DATA_W-1:0] pc_out
);
  logic finished;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       finished <= 1'b0;
    else if (!por_ok) finished <= 1'b0;
    else if (boot_done) finished <= 1'b1;
  end

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done);

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_req_valid && !flash_req_ready && por_ok) |=>
      (flash_req_valid && $stable(flash_req_addr)));

  a_r2_por_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (!flash_req_valid && !boot_done && !map_rom));

  a_r4_rom_map: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && rom_boot) |-> map_rom);

  a_r6_app_map: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !rom_boot) |-> !map_rom);

  a_r5_no_erased_app: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !rom_boot) |-> (pc_out != '1));

  a_r11_hold_after: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && por_ok) |->
      ($stable(sp_out) && $stable(pc_out) && $stable(map_rom) && !flash_req_valid));
endmodule

bind boot_src_seq boot_src_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_ok(por_ok),
  .flash_req_valid(flash_req_valid), .flash_req_ready(flash_req_ready),
  .flash_req_addr(flash_req_addr), .map_rom(map_rom), .rom_boot(rom_boot),
  .boot_done(boot_done), .sp_out(sp_out), .pc_out(pc_out)
);

// File: tb/tb_boot_src_seq.sv
module tb_boot_src_seq;
  localparam logic [31:0] R_SP  = 32'h2000_1000;
  localparam logic [31:0] R_PC  = 32'h0100_0101;
  localparam logic [31:0] A_SP  = 32'h2000_0400;
  localparam logic [31:0] A_PC  = 32'h0000_0101;
  localparam logic [31:0] ERASE = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [31:0] cfg;
    logic [63:0] gpio;
    logic [31:0] m4;
    logic        rom;
    logic [7:0]  lat;
    logic [7:0]  reads;
  } vec_t;

  // R3 R4 R5 R6 R7: path, latency and read count per configuration/pin pattern
  localparam vec_t VECS [8] = '{
    '{32'h0000_3C01, 64'h0,                   A_PC,  1'b1, 8'd2, 8'd0},
    '{32'h0000_3C01, 64'h8000,                ERASE, 1'b1, 8'd4, 8'd1},
    '{32'h0000_3C01, 64'h8000,                A_PC,  1'b0, 8'd6, 8'd2},
    '{32'h0000_3CFE, 64'h0,                   A_PC,  1'b1, 8'd2, 8'd0},
    '{32'h0000_3D01, 64'h0,                   A_PC,  1'b0, 8'd6, 8'd2},
    '{32'h0000_AA00, 64'h0000_0400_0000_0000, A_PC,  1'b1, 8'd2, 8'd0},
    '{32'h0000_AA00, 64'hFFFF_FBFF_FFFF_FFFF, A_PC,  1'b0, 8'd6, 8'd2},
    '{32'h0000_3C01, 64'hFFFF_FFFF_FFFF_7FFF, A_PC,  1'b1, 8'd2, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_ok = 1'b1;
  logic [31:0] boot_cfg = '0;
  logic [63:0] gpio_levels = '0;
  logic        flash_req_valid, flash_req_ready = 1'b1;
  logic [31:0] flash_req_addr;
  logic        flash_rsp_valid = 1'b0;
  logic [31:0] flash_rsp_data = '0;
  logic        map_rom, rom_boot, boot_done;
  logic [31:0] sp_out, pc_out;

  logic [31:0] mem0 = A_SP, mem4 = A_PC;
  int          rd_cnt = 0;
  logic [31:0] first_addr = '0, second_addr = '0;
  int          errors = 0, checks = 0;
  int          lat;

  always #2 clk = ~clk;

  boot_src_seq #(.ROM_SP(R_SP), .ROM_PC(R_PC)) dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .boot_cfg(boot_cfg),
    .gpio_levels(gpio_levels), .flash_req_valid(flash_req_valid),
    .flash_req_ready(flash_req_ready), .flash_req_addr(flash_req_addr),
    .flash_rsp_valid(flash_rsp_valid), .flash_rsp_data(flash_rsp_data),
    .map_rom(map_rom), .rom_boot(rom_boot), .boot_done(boot_done),
    .sp_out(sp_out), .pc_out(pc_out)
  );

  // flash model: one-cycle latency after an accepted request
  always @(posedge clk) begin
    flash_rsp_valid <= 1'b0;
    if (flash_req_valid && flash_req_ready) begin
      flash_rsp_valid <= 1'b1;
      flash_rsp_data  <= (flash_req_addr == 32'h4) ? mem4 :
                         (flash_req_addr == 32'h0) ? mem0 : 32'hDEAD_BEEF;
      if (rd_cnt == 0) first_addr = flash_req_addr;
      if (rd_cnt == 1) second_addr = flash_req_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!boot_done && n < 60);
  endtask

  task automatic start(input logic [31:0] c, input logic [63:0] g,
                       input logic [31:0] m4v);
    @(negedge clk);
    rst_n = 1'b0; por_ok = 1'b1; flash_req_ready = 1'b1;
    boot_cfg = c; gpio_levels = g; mem0 = A_SP; mem4 = m4v;
    @(negedge clk);
    rd_cnt = 0; first_addr = '0; second_addr = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    chk("R1 done", boot_done, 0);
    chk("R1 map", map_rom, 0);
    chk("R1 rom", rom_boot, 0);
    chk("R1 req", flash_req_valid, 0);
    chk("R1 sp/pc", {sp_out, pc_out}, 64'h0);

    for (int i = 0; i < 8; i++) begin
      start(VECS[i].cfg, VECS[i].gpio, VECS[i].m4);
      wait_done(lat);
      chk($sformatf("R4/R5/R6 v%0d latency", i), lat, VECS[i].lat);
      chk($sformatf("R3/R7 v%0d rom_boot", i), rom_boot, VECS[i].rom);
      chk($sformatf("R4/R6 v%0d map", i), map_rom, VECS[i].rom);
      chk($sformatf("R4/R6 v%0d sp", i), sp_out, VECS[i].rom ? R_SP : A_SP);
      chk($sformatf("R4/R6 v%0d pc", i), pc_out, VECS[i].rom ? R_PC : A_PC);
      chk($sformatf("R4/R5 v%0d reads", i), rd_cnt, VECS[i].reads);
      if (VECS[i].reads > 0) chk($sformatf("R5 v%0d first addr", i), first_addr, 32'h4);
      if (VECS[i].reads > 1) chk($sformatf("R6 v%0d second addr", i), second_addr, 32'h0);
      @(negedge clk);
      chk($sformatf("R8 v%0d pulse", i), boot_done, 0);
    end

    // R11: values hold and no reads after completion
    begin
      logic [31:0] s0, p0;
      int r0;
      s0 = sp_out; p0 = pc_out; r0 = rd_cnt;
      repeat (5) @(negedge clk);
      chk("R11 hold", {sp_out, pc_out}, {s0, p0});
      chk("R11 no reads", rd_cnt, r0);
      chk("R8 single pulse", boot_done, 0);
    end

    // R2: por_ok low holds the sequence
    @(negedge clk);
    rst_n = 1'b0; boot_cfg = 32'h0000_0100; mem4 = A_PC;
    @(negedge clk);
    rst_n = 1'b1; por_ok = 1'b0; rd_cnt = 0;
    repeat (5) @(negedge clk);
    chk("R2 no req", flash_req_valid, 0);
    chk("R2 no done", boot_done, 0);
    chk("R2 no reads", rd_cnt, 0);
    por_ok = 1'b1;
    wait_done(lat);
    chk("R2 latency after release", lat, 6);
    chk("R2 pc", pc_out, A_PC);

    // R9: back-pressure on the request channel
    start(32'h0000_0100, 64'h0, A_PC);
    flash_req_ready = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 req held", flash_req_valid, 1);
    chk("R9 addr held", flash_req_addr, 32'h4);
    chk("R9 no accept", rd_cnt, 0);
    flash_req_ready = 1'b1;
    wait_done(lat);
    chk("R9 stalled latency", lat + 6, 10);
    chk("R9 sp", sp_out, A_SP);

    // R10: reset in mid-sequence restarts
    start(32'h0000_0100, 64'h0, A_PC);
    repeat (4) @(negedge clk);
    rst_n = 1'b0; mem4 = ERASE;
    @(negedge clk);
    chk("R10 abort req", flash_req_valid, 0);
    chk("R10 abort map", map_rom, 0);
    rd_cnt = 0;
    rst_n = 1'b1;
    wait_done(lat);
    chk("R10 restart latency", lat, 4);
    chk("R10 rom path", {rom_boot, map_rom}, 2'b11);
    chk("R10 reads", rd_cnt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule